// File: doc/BRIEF.md
# Configuration register slave on a two-wire serial bus

This block is a slave on a standard two-wire serial bus (I2C-compatible, 7-bit addressing). It gives a bus master read and write access to a bank of byte-wide configuration registers. The register bank drives the rest of the chip through a flat output vector. The slave address is fixed by a parameter. The first byte after the address is a command code. Its top bit chooses a single-register access at a given offset or a block access that always starts at offset 0. A block write carries a byte count. A block read returns a byte count ahead of the data.

One window of offsets is staged. Writes that land inside it go to a shadow store and stay invisible on the outputs. The whole set of pending shadow bytes moves into the live registers in the same cycle as the next write that lands outside the window. Software must therefore finish every burst into the window with one write elsewhere.

Both bus lines pass through synchronisers into the system clock, and SDA is driven open-drain through an enable. The slave never stretches SCL and applies no back-pressure of any kind. Every byte addressed to it is handled at bus speed. For this to work, the system clock must run well above the SCL rate, so that each SCL low phase lasts at least five system clocks.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal DEV_ADDR (default 7'h69, i.e. write byte D2h). On any other address it leaves SDA released and ignores the rest of the transfer.
- R2: A command byte with bit 7 = 1 selects single-byte mode, and bits 6:0 give the offset. The one data byte that follows is written to that offset and acknowledged. A further data byte in the same transfer is not acknowledged and not written.
- R3: After a single-byte command, a repeated START with the read address returns the live value of the register at that offset, MSB first.
- R4: A command byte of 00h selects block mode. The next byte is a count N, and the following N data bytes are written to offsets 0, 1, … N-1 in ascending order, each one acknowledged. A data byte beyond N is not acknowledged and not written.
- R5: After a block command, a repeated START with the read address first returns the count byte NREG (default 128). It then returns the live registers from offset 0 upward while the master acknowledges, and ends on the master's NACK.
- R6: A write to an offset from WIN_LO to WIN_HI (default 32 to 63) leaves the live registers unchanged and is held in a shadow store. When a later write lands outside that window, every held byte is copied into the live registers in the same cycle, and the store is then empty.
- R7: On reset every live register k takes the value k XOR 8'h5A, and no shadow byte is pending.
- R8: For INIT_CYCLES clocks after reset is released (default 512), the slave ignores the bus entirely and never drives SDA.
- R9: A START or STOP seen in the middle of a byte returns the slave to address reception or to idle. A partially received data byte is never written.
- R10: The slave changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_regs | output | NREG*8 | Live registers; byte k is bits k*8+7 to k*8 |

## Verification
The bench checks the data byte that arrives after the count in a block write is exhausted. A design that miscounted would acknowledge that byte and corrupt offset N. It checks a byte read of an offset inside the staged window. A design that read the shadow store would return the pending value there instead of the live one. It checks the commit path by comparing the full register vector before and after a write outside the window. A design that committed only the last held byte, or committed on a write inside the window, would show stale or early bytes. It also aborts a data byte halfway with STOP and restarts a transfer with a repeated START after a few bits. A design that latched partial bytes or kept its bit counter would then write garbage or fail to acknowledge the next address.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_PRE, ST_RX_ACK, ST_TX, ST_TX_ACK
  } bus_st_t;

  typedef enum logic [1:0] {K_ADDR, K_CMD, K_CNT, K_DATA} rx_kind_t;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    return 8'(idx) ^ 8'h5A;
  endfunction

endpackage

// File: rtl/i2creg_line_sync.sv
module i2creg_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[SYNC_STAGES-1];
  assign sda_lvl   = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2creg_bank.sv
module i2creg_bank
  import i2creg_pkg::*;
#(
  parameter int NREG   = 128,
  parameter int WIN_LO = 32,
  parameter int WIN_HI = 63,
  parameter int AW     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] live_flat
);
  localparam int WIN_N = WIN_HI - WIN_LO + 1;
  localparam int WW    = (WIN_N > 1) ? $clog2(WIN_N) : 1;
  localparam logic [AW-1:0] LO_A = AW'(WIN_LO);
  localparam logic [AW-1:0] HI_A = AW'(WIN_HI);

  logic [WIN_N-1:0][7:0] shadow_q;
  logic [WIN_N-1:0]      pend_q;
  logic                  in_win, commit;
  logic [WW-1:0]         win_idx;

  assign in_win  = (wr_addr >= LO_A) && (wr_addr <= HI_A);
  assign commit  = wr_en && !in_win;
  assign win_idx = WW'(wr_addr - LO_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= '0;
    end else if (wr_en) begin
      if (in_win) begin
        shadow_q[win_idx] <= wr_data;
        pend_q[win_idx]   <= 1'b1;
      end else begin
        pend_q <= '0;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] r_q;
    if (g >= WIN_LO && g <= WIN_HI) begin : g_staged
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= reg_default(g);
        else if (commit && pend_q[g-WIN_LO]) r_q <= shadow_q[g-WIN_LO];
      end
    end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= reg_default(g);
        else if (wr_en && wr_addr == AW'(g)) r_q <= wr_data;
      end
    end
    assign live_flat[g*8 +: 8] = r_q;
  end

  assign rd_data = live_flat[{rd_addr, 3'b000} +: 8];

  // R6: a write inside the window never reaches the live bank in that cycle
  assert_window_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_win) |=> $stable(live_flat));
  // R6: the live bank moves only in response to a write
  assert_live_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(live_flat));
endmodule

// File: rtl/i2creg_proto.sv
module i2creg_proto
  import i2creg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 128,
  parameter int         AW          = $clog2(NREG),
  parameter int         INIT_CYCLES = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr
);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam logic [7:0] CNT_B = 8'(NREG);

  bus_st_t       st;
  rx_kind_t      kind;
  logic [IW-1:0] init_cnt;
  logic          init_done;
  logic [2:0]    bitcnt;
  logic [7:0]    sh, txb, left;
  logic [AW-1:0] ptr;
  logic          ack_q, go_tx, byte_mode, byte_used, cnt_first;
  logic          rx_done, data_ok;
  logic [7:0]    rx_byte;

  assign init_done = (init_cnt == IW'(INIT_CYCLES));
  assign rx_byte   = {sh[6:0], sda_lvl};
  assign rx_done   = (st == ST_RX) && scl_rise && (bitcnt == 3'd7);
  assign data_ok   = byte_mode ? !byte_used : (left != 8'd0);
  assign wr_en     = rx_done && (kind == K_DATA) && data_ok;
  assign wr_addr   = ptr;
  assign wr_data   = rx_byte;
  assign rd_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= K_ADDR; init_cnt <= '0; bitcnt <= '0;
      sh <= '0; txb <= '0; left <= '0; ptr <= '0; sda_oe <= 1'b0;
      ack_q <= 1'b0; go_tx <= 1'b0; byte_mode <= 1'b0;
      byte_used <= 1'b0; cnt_first <= 1'b0;
    end else begin
      if (!init_done) init_cnt <= init_cnt + 1'b1;
      if (!init_done) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else if (start_evt) begin
        st <= ST_RX; kind <= K_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: if (scl_rise) begin
            sh     <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              st    <= ST_RX_PRE;
              go_tx <= 1'b0;
              ack_q <= 1'b1;
              case (kind)
                K_ADDR: begin
                  if (rx_byte[7:1] != DEV_ADDR) st <= ST_IDLE;
                  else if (rx_byte[0]) begin
                    go_tx <= 1'b1; cnt_first <= !byte_mode;
                  end else kind <= K_CMD;
                end
                K_CMD: begin
                  byte_mode <= rx_byte[7];
                  byte_used <= 1'b0;
                  ptr  <= rx_byte[7] ? rx_byte[AW-1:0] : '0;
                  kind <= rx_byte[7] ? K_DATA : K_CNT;
                end
                K_CNT: begin
                  left <= rx_byte; kind <= K_DATA;
                end
                default: begin
                  ack_q <= data_ok;
                  if (data_ok) begin
                    ptr <= ptr + 1'b1; byte_used <= 1'b1;
                    if (!byte_mode) left <= left - 8'd1;
                  end
                end
              endcase
            end
          end
          ST_RX_PRE: if (scl_fall) begin
            sda_oe <= ack_q; st <= ST_RX_ACK;
          end
          ST_RX_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            if (!ack_q) st <= ST_IDLE;
            else if (go_tx) begin
              st <= ST_TX;
              if (cnt_first) begin
                txb <= CNT_B; sda_oe <= ~CNT_B[7];
              end else begin
                txb <= rd_data; sda_oe <= ~rd_data[7]; ptr <= ptr + 1'b1;
              end
            end else st <= ST_RX;
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0; st <= ST_TX_ACK;
            end else begin
              bitcnt <= bitcnt + 3'd1;
              sda_oe <= ~txb[6];
              txb    <= {txb[6:0], 1'b0};
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) ack_q <= ~sda_lvl;
            if (scl_fall) begin
              if (ack_q) begin
                st <= ST_TX; bitcnt <= '0;
                txb <= rd_data; sda_oe <= ~rd_data[7]; ptr <= ptr + 1'b1;
              end else st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);
  assert_quiet_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !sda_oe);
  assert_read_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX || st == ST_TX_ACK) |-> !wr_en);
  assert_idle_no_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 128,
  parameter int         WIN_LO      = 32,
  parameter int         WIN_HI      = 63,
  parameter int         INIT_CYCLES = 512,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_regs
);
  localparam int AW = $clog2(NREG);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  i2creg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt));

  i2creg_proto #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .AW(AW),
                 .INIT_CYCLES(INIT_CYCLES)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr));

  i2creg_bank #(.NREG(NREG), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .live_flat(cfg_regs));
endmodule

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;
  localparam int H = 10;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [1023:0] cfg_regs;
  wire  sda_line = !(m_low || sda_oe);

  int n_chk = 0, n_bad = 0, r10_viol = 0;
  logic [7:0] m_live [128];
  logic [7:0] m_sh [32];
  bit         m_pend [32];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];

  always #10 clk = ~clk;

  cfg_i2c_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
                     .sda_oe(sda_oe), .cfg_regs(cfg_regs));

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe != prev_oe) && scl_m) r10_viol++;
    prev_oe <= sda_oe;
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic chk_regs(input string rq);
    int bad_k = -1;
    n_chk++;
    for (int k = 127; k >= 0; k--) if (cfg_regs[k*8 +: 8] !== m_live[k]) bad_k = k;
    if (bad_k >= 0) begin
      n_bad++;
      $display("FAIL %s: reg %0d actual %0h expected %0h", rq, bad_k,
               cfg_regs[bad_k*8 +: 8], m_live[bad_k]);
    end
  endtask

  task automatic model_wr(input int a, input logic [7:0] d);
    if (a >= 32 && a <= 63) begin
      m_sh[a-32] = d; m_pend[a-32] = 1'b1;
    end else begin
      m_live[a] = d;
      for (int i = 0; i < 32; i++) if (m_pend[i]) begin
        m_live[32+i] = m_sh[i]; m_pend[i] = 1'b0;
      end
    end
  endtask

  task automatic i2c_start;
    m_low = 1'b0; wt(Q); scl_m = 1'b1; wt(H); m_low = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
  endtask
  task automatic i2c_stop;
    m_low = 1'b1; wt(Q); scl_m = 1'b1; wt(H); m_low = 1'b0; wt(H);
  endtask
  task automatic put_bit(input logic b);
    m_low = !b; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
  endtask
  task automatic get_bit(output logic b);
    m_low = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); b = sda_line; wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b); ack = !b;
  endtask
  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(nack);
  endtask

  task automatic byte_write(input int off, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i2c_start; send_byte(8'hD2, a0); send_byte({1'b1, 7'(off)}, a1); send_byte(d, a2); i2c_stop;
    ok = a0 & a1 & a2;
    model_wr(off, d);
  endtask

  task automatic byte_read(input int off, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i2c_start; send_byte(8'hD2, a0); send_byte({1'b1, 7'(off)}, a1);
    i2c_start; send_byte(8'hD3, a2); recv_byte(1'b1, d); i2c_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic block_write(input int n, input bit extra, output logic ok, output logic xack);
    logic a0, a1, a2, ad;
    i2c_start; send_byte(8'hD2, a0); send_byte(8'h00, a1); send_byte(8'(n), a2);
    ok = a0 & a1 & a2;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], ad); ok &= ad; model_wr(i, wbuf[i]); end
    xack = 1'b0;
    if (extra) send_byte(8'hC3, xack);
    i2c_stop;
  endtask

  task automatic block_read(input int k, output logic [7:0] cnt, output logic ok);
    logic a0, a1, a2;
    i2c_start; send_byte(8'hD2, a0); send_byte(8'h00, a1);
    i2c_start; send_byte(8'hD3, a2); recv_byte(1'b0, cnt);
    for (int i = 0; i < k; i++) recv_byte(i == k-1, rbuf[i]);
    i2c_stop;
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ok, xk, a0;
    logic [7:0] d, cnt;
    void'($urandom(32'd4242));
    for (int k = 0; k < 128; k++) m_live[k] = 8'(k) ^ 8'h5A;
    for (int i = 0; i < 32; i++) begin m_sh[i] = 8'h00; m_pend[i] = 1'b0; end
    wt(5); rst_n = 1'b1;
    wt(1);
    chk_regs("R7 reset defaults");
    chk("R7 sda released", int'(sda_oe), 0);

    // R8: address sent during the init window must not be acknowledged
    i2c_start; send_byte(8'hD2, a0); i2c_stop;
    chk("R8 no ack during init", int'(a0), 0);
    wt(600);

    // R1: foreign address, then bytes that would write offset 5
    i2c_start; send_byte(8'hDA, a0); send_byte(8'h85, xk); send_byte(8'h11, xk); i2c_stop;
    chk("R1 foreign address nack", int'(a0), 0);
    chk_regs("R1 foreign transfer ignored");

    // R2 / R3 directed
    byte_write(5, 8'hA7, ok);
    chk("R2 byte write acked", int'(ok), 1);
    chk("R2 byte write value", int'(cfg_regs[5*8 +: 8]), 8'hA7);
    byte_read(5, d, ok);
    chk("R3 byte read", int'(d), 8'hA7);
    // R2: second data byte in single mode is refused
    i2c_start; send_byte(8'hD2, a0); send_byte(8'h86, a0); send_byte(8'h31, a0);
    send_byte(8'h32, xk); i2c_stop;
    model_wr(6, 8'h31);
    chk("R2 extra byte nack", int'(xk), 0);
    chk("R2 extra byte not written", int'(cfg_regs[7*8 +: 8]), 8'h5D);

    // R4: block write with one byte past the count
    for (int i = 0; i < 12; i++) wbuf[i] = 8'($urandom);
    block_write(12, 1'b1, ok, xk);
    chk("R4 block write acked", int'(ok), 1);
    chk("R4 byte past count nack", int'(xk), 0);
    chk_regs("R4 block contents");

    // R5: block read count and ascending bytes
    block_read(16, cnt, ok);
    chk("R5 count byte", int'(cnt), 128);
    for (int i = 0; i < 16; i++) chk("R5 block data", int'(rbuf[i]), int'(m_live[i]));

    // R6: staged window
    byte_write(40, 8'h3C, ok);
    chk("R6 held not live", int'(cfg_regs[40*8 +: 8]), int'(8'd40 ^ 8'h5A));
    byte_read(40, d, ok);
    chk("R6 read returns live", int'(d), int'(8'd40 ^ 8'h5A));
    byte_write(45, 8'h77, ok);
    chk_regs("R6 still held");
    byte_write(3, 8'hE1, ok);
    chk("R6 commit 40", int'(cfg_regs[40*8 +: 8]), 8'h3C);
    chk("R6 commit 45", int'(cfg_regs[45*8 +: 8]), 8'h77);
    chk_regs("R6 after commit");
    for (int i = 0; i < 36; i++) wbuf[i] = 8'($urandom);
    block_write(36, 1'b0, ok, xk);
    chk_regs("R6 block tail held");
    byte_write(70, 8'h09, ok);
    chk_regs("R6 block tail committed");

    // R9: STOP in mid data byte, then START in mid data byte
    i2c_start; send_byte(8'hD2, a0); send_byte(8'h8A, a0);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); i2c_stop;
    chk_regs("R9 stop mid byte no write");
    i2c_start; send_byte(8'hD2, a0); send_byte(8'h8B, a0);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    byte_write(11, 8'h4E, ok);
    chk("R9 restart after partial", int'(ok), 1);
    chk_regs("R9 restart result");

    // random mix
    for (int n = 0; n < 30; n++) begin
      int off = int'($urandom_range(127, 0));
      if ($urandom_range(1, 0) == 1) begin
        byte_write(off, 8'($urandom), ok);
        chk("R2 random write ack", int'(ok), 1);
      end else begin
        byte_read(off, d, ok);
        chk("R3 random read", int'(d), int'(m_live[off]));
      end
    end
    chk_regs("R6 random final bank");
    chk("R10 drive changes while SCL high", r10_viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule